// File: doc/BRIEF.md
# Keyboard and Display Register Decoder

This block sits between a 16-bit processor bus and main memory. Each bus access carries an address, write data and a write flag. When the address matches one of four device registers, the block serves the access from its own registers and keeps memory disabled. Every other address goes on to memory unchanged, and memory's read data is returned to the bus.

The four registers hold state for two devices, a keyboard and a display.

- **Keyboard.** A keyboard strobe captures a character and raises the keyboard ready flag. Reading the keyboard data word consumes the character and lowers the flag.
- **Display.** Writing the display data word hands a character to the display with a one-cycle strobe. The display ready flag then drops for a programmable busy time.

Each device also has an interrupt-enable bit. A device that is ready and enabled is pending. The block reports the priority level of the strongest pending device. It raises a request only when that level is strictly above the running program's level. A grant is given when the processor signals that it is about to fetch.

Top module: `kbdDispIoCtl`

## Requirements
- R1: Only the addresses 0xFE00 (keyboard status), 0xFE02 (keyboard data), 0xFE04 (display status) and 0xFE06 (display data) are device registers.
  - An access to one of them holds memEn and memWe low, and busRdData shows that register.
  - Any other address with busEn high drives memEn high and sets memWe equal to busWe.
  - For any other address, busRdData equals memRdData.
- R2: After reset:
  - keyboard status reads 0x0000;
  - display status reads 0x8000;
  - dispStrobe, irqReq and irqGrant are low;
  - irqLevel is 0.
- R3: Keyboard character path:
  - A kbdStrobe cycle loads kbdChar into bits 7:0 of 0xFE02 (upper bits read 0) and sets bit 15 of 0xFE00.
  - A read of 0xFE02 clears that bit at the next clock edge.
  - When a strobe and such a read fall in the same cycle, the bit stays set.
- R4: Writing a status register changes only its bit 14 (interrupt enable). Bit 15 keeps its value, and bits 13:0 read as 0.
- R5: Writing 0xFE06:
  - stores bits 7:0 on dispChar;
  - raises dispStrobe for exactly the one cycle after the write edge;
  - clears bit 15 of 0xFE04 for DISP_BUSY cycles, after which the bit is set again.
- R6: Writing 0xFE02 changes neither the keyboard character nor the keyboard ready bit.
- R7: Interrupt priority level:
  - A device is pending when its bit 15 and bit 14 are both 1.
  - irqLevel is the priority (KBD_PRIO or DISP_PRIO) of the highest pending device, with the keyboard winning ties.
  - irqLevel is 0 with nothing pending.
- R8: Interrupt request and grant:
  - irqReq is high only when a device is pending and irqLevel is strictly greater than runPriority.
  - irqGrant equals irqReq while fetchCheck is high and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busEn | input | 1 | Bus access valid this cycle |
| busWe | input | 1 | Access is a write |
| busAddr | input | 16 | Bus address |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data (device register or memory) |
| memEn | output | 1 | Memory enable |
| memWe | output | 1 | Memory write enable |
| memRdData | input | 16 | Memory read data |
| kbdStrobe | input | 1 | New keyboard character valid |
| kbdChar | input | 8 | Keyboard character |
| dispStrobe | output | 1 | Display character valid |
| dispChar | output | 8 | Display character |
| runPriority | input | 3 | Priority level of running program |
| fetchCheck | input | 1 | Processor is at the point before a fetch |
| irqReq | output | 1 | Interrupt request above running level |
| irqLevel | output | 3 | Level of highest pending device |
| irqGrant | output | 1 | Request granted at fetch check |

## Verification
The assertions rely on three conditions on the inputs:
- busEn is low whenever the other bus inputs are meaningless.
- kbdStrobe is a single-cycle pulse per character.
- Reset is held for at least one clock edge.

The bench meets these conditions by driving every input at the falling edge, raising busEn for exactly one cycle per access, and pulsing kbdStrobe for one cycle. One stimulus, a keyboard strobe coinciding with a data read, is deliberately overlapped to exercise the same-cycle rule of R3.

// File: rtl/ioPkg.sv
package ioPkg;
  typedef struct packed {
    logic       isDev;
    logic [1:0] regSel;
    logic       kbdDataRd;
    logic       kbdStatWr;
    logic       dispStatWr;
    logic       dispDataWr;
  } ctlStrobes_t;

  localparam logic [1:0] SEL_KSTAT = 2'd0;
  localparam logic [1:0] SEL_KDATA = 2'd1;
  localparam logic [1:0] SEL_DSTAT = 2'd2;
  localparam logic [1:0] SEL_DDATA = 2'd3;
endpackage

// File: rtl/ioCtrl.sv
module ioCtrl
  import ioPkg::*;
#(
  parameter logic [15:0] DEV_BASE = 16'hFE00
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busEn,
  input  logic        busWe,
  input  logic [15:0] busAddr,
  output logic        memEn,
  output logic        memWe,
  output ctlStrobes_t ctl
);
  localparam logic [15:0] SEL_MASK = 16'h0006;

  logic devHit;
  assign devHit = (busAddr & ~SEL_MASK) == DEV_BASE;

  always_comb begin
    ctl            = '0;
    ctl.isDev      = devHit;
    ctl.regSel     = busAddr[2:1];
    ctl.kbdDataRd  = busEn && devHit && !busWe && (busAddr[2:1] == SEL_KDATA);
    ctl.kbdStatWr  = busEn && devHit && busWe  && (busAddr[2:1] == SEL_KSTAT);
    ctl.dispStatWr = busEn && devHit && busWe  && (busAddr[2:1] == SEL_DSTAT);
    ctl.dispDataWr = busEn && devHit && busWe  && (busAddr[2:1] == SEL_DDATA);
  end

  assign memEn = busEn && !devHit;
  assign memWe = memEn && busWe;

  // R1
  mem_dev_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    memEn |-> !(ctl.kbdDataRd || ctl.kbdStatWr || ctl.dispStatWr || ctl.dispDataWr));

  // R1
  mem_we_only_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memEn);
endmodule

// File: rtl/ioDatapath.sv
module ioDatapath
  import ioPkg::*;
#(
  parameter int          DISP_BUSY = 4,
  parameter logic [2:0]  KBD_PRIO  = 3'd4,
  parameter logic [2:0]  DISP_PRIO = 3'd2
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t ctl,
  input  logic [15:0] busWrData,
  input  logic [15:0] memRdData,
  output logic [15:0] busRdData,
  input  logic        kbdStrobe,
  input  logic [7:0]  kbdChar,
  output logic        dispStrobe,
  output logic [7:0]  dispChar,
  input  logic [2:0]  runPriority,
  input  logic        fetchCheck,
  output logic        irqReq,
  output logic [2:0]  irqLevel,
  output logic        irqGrant
);
  localparam int CNT_W = $clog2(DISP_BUSY + 1);
  localparam logic [CNT_W-1:0] BUSY_LOAD = CNT_W'(DISP_BUSY);

  logic             kbdReady, kbdIe, dispIe;
  logic [7:0]       kbdCharReg;
  logic [CNT_W-1:0] busyCnt;
  logic             dispReady;
  logic             unusedWrBits;

  assign unusedWrBits = ^{busWrData[15], busWrData[13:8]};
  assign dispReady    = (busyCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kbdReady   <= 1'b0;
      kbdIe      <= 1'b0;
      dispIe     <= 1'b0;
      kbdCharReg <= '0;
      dispChar   <= '0;
      dispStrobe <= 1'b0;
      busyCnt    <= '0;
    end else begin
      if (kbdStrobe) begin
        kbdCharReg <= kbdChar;
        kbdReady   <= 1'b1;
      end else if (ctl.kbdDataRd) begin
        kbdReady   <= 1'b0;
      end
      if (ctl.kbdStatWr)  kbdIe  <= busWrData[14];
      if (ctl.dispStatWr) dispIe <= busWrData[14];
      dispStrobe <= ctl.dispDataWr;
      if (ctl.dispDataWr) begin
        dispChar <= busWrData[7:0];
        busyCnt  <= BUSY_LOAD;
      end else if (busyCnt != '0) begin
        busyCnt  <= busyCnt - 1'b1;
      end
    end
  end

  always_comb begin
    busRdData = memRdData;
    if (ctl.isDev) begin
      unique case (ctl.regSel)
        SEL_KSTAT: busRdData = {kbdReady, kbdIe, 14'b0};
        SEL_KDATA: busRdData = {8'b0, kbdCharReg};
        SEL_DSTAT: busRdData = {dispReady, dispIe, 14'b0};
        default:   busRdData = {8'b0, dispChar};
      endcase
    end
  end

  logic kbdPend, dispPend;
  assign kbdPend  = kbdReady && kbdIe;
  assign dispPend = dispReady && dispIe;

  always_comb begin
    if (kbdPend && (!dispPend || KBD_PRIO >= DISP_PRIO)) irqLevel = KBD_PRIO;
    else if (dispPend)                                    irqLevel = DISP_PRIO;
    else                                                  irqLevel = 3'd0;
  end

  assign irqReq   = (kbdPend || dispPend) && (irqLevel > runPriority);
  assign irqGrant = irqReq && fetchCheck;

  // R3
  kbd_rise_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(kbdReady) |-> $past(kbdStrobe));

  // R3
  kbd_consume_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.kbdDataRd && !kbdStrobe) |=> !kbdReady);

  // R5
  disp_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    dispStrobe |-> !dispReady);

  // R7
  irq_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> ((kbdReady && kbdIe) || (dispReady && dispIe)));

  // R8
  grant_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqGrant |-> (fetchCheck && irqReq));
endmodule

// File: rtl/kbdDispIoCtl.sv
module kbdDispIoCtl
  import ioPkg::*;
#(
  parameter logic [15:0] DEV_BASE  = 16'hFE00,
  parameter int          DISP_BUSY = 4,
  parameter logic [2:0]  KBD_PRIO  = 3'd4,
  parameter logic [2:0]  DISP_PRIO = 3'd2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busEn,
  input  logic        busWe,
  input  logic [15:0] busAddr,
  input  logic [15:0] busWrData,
  output logic [15:0] busRdData,
  output logic        memEn,
  output logic        memWe,
  input  logic [15:0] memRdData,
  input  logic        kbdStrobe,
  input  logic [7:0]  kbdChar,
  output logic        dispStrobe,
  output logic [7:0]  dispChar,
  input  logic [2:0]  runPriority,
  input  logic        fetchCheck,
  output logic        irqReq,
  output logic [2:0]  irqLevel,
  output logic        irqGrant
);
  ctlStrobes_t ctl;

  ioCtrl #(.DEV_BASE(DEV_BASE)) uCtrl (
    .clk(clk), .rstN(rstN), .busEn(busEn), .busWe(busWe), .busAddr(busAddr),
    .memEn(memEn), .memWe(memWe), .ctl(ctl)
  );

  ioDatapath #(.DISP_BUSY(DISP_BUSY), .KBD_PRIO(KBD_PRIO), .DISP_PRIO(DISP_PRIO)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .busWrData(busWrData), .memRdData(memRdData),
    .busRdData(busRdData), .kbdStrobe(kbdStrobe), .kbdChar(kbdChar),
    .dispStrobe(dispStrobe), .dispChar(dispChar), .runPriority(runPriority),
    .fetchCheck(fetchCheck), .irqReq(irqReq), .irqLevel(irqLevel), .irqGrant(irqGrant)
  );
endmodule

// File: tb/tb_kbdDispIoCtl.sv
module tb_kbdDispIoCtl;
  logic clk = 1'b0, rstN = 1'b0;
  logic busEn = 0, busWe = 0;
  logic [15:0] busAddr = '0, busWrData = '0, memRdData = 16'hA5A5;
  logic [15:0] busRdData;
  logic memEn, memWe, kbdStrobe = 0, dispStrobe, fetchCheck = 0;
  logic irqReq, irqGrant;
  logic [7:0] kbdChar = '0, dispChar;
  logic [2:0] runPriority = '0, irqLevel;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  kbdDispIoCtl dut (.*);

  // {addr, we, expMemEn, expMemWe}
  localparam logic [18:0] VEC [10] = '{
    {16'hFE00, 1'b0, 1'b0, 1'b0}, {16'hFE02, 1'b0, 1'b0, 1'b0},
    {16'hFE04, 1'b1, 1'b0, 1'b0}, {16'hFE06, 1'b0, 1'b0, 1'b0},
    {16'hFE01, 1'b1, 1'b1, 1'b1}, {16'hFE08, 1'b0, 1'b1, 1'b0},
    {16'h0000, 1'b1, 1'b1, 1'b1}, {16'hFFFF, 1'b0, 1'b1, 1'b0},
    {16'h3000, 1'b0, 1'b1, 1'b0}, {16'hFDFE, 1'b1, 1'b1, 1'b1}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [15:0] a, input logic [15:0] d);
    busEn = 1; busWe = 1; busAddr = a; busWrData = d;
    @(negedge clk);
    busEn = 0; busWe = 0;
  endtask

  task automatic busRead(input logic [15:0] a, output logic [15:0] d);
    busEn = 1; busWe = 0; busAddr = a;
    #2 d = busRdData;
    @(negedge clk);
    busEn = 0;
  endtask

  task automatic pulseKbd(input logic [7:0] c);
    kbdStrobe = 1; kbdChar = c;
    @(negedge clk);
    kbdStrobe = 0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1;

    // R2 reset state
    busRead(16'hFE00, rd); check("R2 kstat", rd, 16'h0000);
    busRead(16'hFE04, rd); check("R2 dstat", rd, 16'h8000);
    check("R2 irq", {dispStrobe, irqReq, irqGrant, irqLevel}, 16'h0000);

    // R1 decode table
    for (int i = 0; i < 10; i++) begin
      busEn = 1; busAddr = VEC[i][18:3]; busWe = VEC[i][2];
      #2 check("R1 mem", {memEn, memWe}, {14'b0, VEC[i][1:0]});
      @(negedge clk); busEn = 0; busWe = 0;
    end
    busRead(16'h3000, rd); check("R1 passthrough", rd, 16'hA5A5);

    // R4 status writes
    busWrite(16'hFE00, 16'hFFFF);
    busRead(16'hFE00, rd); check("R4 kstat ie only", rd, 16'h4000);
    busWrite(16'hFE04, 16'h0000);
    busRead(16'hFE04, rd); check("R4 dstat ready kept", rd, 16'h8000);
    busWrite(16'hFE00, 16'h0000);

    // R3 keyboard
    pulseKbd(8'h41);
    busRead(16'hFE00, rd); check("R3 ready set", rd, 16'h8000);
    busRead(16'hFE02, rd); check("R3 char", rd, 16'h0041);
    busRead(16'hFE00, rd); check("R3 ready cleared", rd, 16'h0000);
    kbdStrobe = 1; kbdChar = 8'h5A;
    busRead(16'hFE02, rd);
    kbdStrobe = 0;
    busRead(16'hFE00, rd); check("R3 strobe wins", rd, 16'h8000);

    // R6 keyboard data write ignored
    busWrite(16'hFE02, 16'h00FF);
    busRead(16'hFE02, rd); check("R6 char unchanged", rd, 16'h005A);
    busRead(16'hFE00, rd); check("R6 ready cleared only by read", rd, 16'h0000);

    // R7/R8 priority: display only, prio 2
    busWrite(16'hFE04, 16'h4000);
    runPriority = 3'd1; #1;
    check("R7 disp level", {13'b0, irqLevel}, 16'd2);
    check("R8 req above", {15'b0, irqReq}, 16'd1);
    check("R8 grant off", {15'b0, irqGrant}, 16'd0);
    fetchCheck = 1; #1;
    check("R8 grant on", {15'b0, irqGrant}, 16'd1);
    runPriority = 3'd2; #1;
    check("R8 equal not granted", {14'b0, irqReq, irqGrant}, 16'd0);
    fetchCheck = 0;
    @(negedge clk);
    busWrite(16'hFE00, 16'h4000);
    pulseKbd(8'h33);
    check("R7 kbd wins", {13'b0, irqLevel}, 16'd4);
    check("R8 req kbd", {15'b0, irqReq}, 16'd1);
    busRead(16'hFE02, rd);
    check("R7 back to disp", {13'b0, irqLevel}, 16'd2);

    // R5 display write and busy window
    busWrite(16'hFE06, 16'hBE62);
    check("R5 strobe", {15'b0, dispStrobe}, 16'd1);
    check("R5 char", {8'b0, dispChar}, 16'h0062);
    check("R7 none pending", {13'b0, irqLevel}, 16'd0);
    for (int k = 0; k < 4; k++) begin
      busRead(16'hFE04, rd); check("R5 busy", rd, 16'h4000);
      if (k == 0) check("R5 strobe one cycle", {15'b0, dispStrobe}, 16'd0);
    end
    busRead(16'hFE04, rd); check("R5 ready again", rd, 16'hC000);
    busRead(16'hFE06, rd); check("R1 disp data read", rd, 16'h0062);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule